// File: doc/BRIEF.md
# Memory Port Bandwidth Monitor

This block sits next to the arbiter of a memory controller and watches its request and grant strobes. Two kinds of requester feed the arbiter: up to 32 major ports, and a device group of up to 16 subports. The monitor keeps one counter of request cycles and one counter of all grants. It also keeps four channel counters. Each channel counts only the grants that pass its own port filter. Software sets the monitor up and reads the results over a simple word-aligned register bus. Read data comes back one cycle after the read strobe.

Each channel filter works in one of two modes. In the first, it selects a set of major ports through a bitmask. In the second, a device-select bit in the same register makes the channel match only device-group grants, and a second register then picks which subports count.

A programmable window timer can bound each measurement. At the end of every window the counts are frozen into readable snapshots, the live counters restart, and an interrupt flag is raised. Software clears that flag by writing the control register back with the flag bit set.

Top module: `mbm_bw_monitor`

## Requirements
- R1: After reset every register reads 0 and `irq` is low.
- R2: Register index i sits at byte address 4*i, and an access whose two low address bits are not zero is ignored. A read returns its data on `reg_rdata` in the cycle after `reg_rd`.
  - Control register (index 0): bit 31 is the global enable, bit 30 is the interrupt flag, bit 20 is window mode, and bits 3:0 are the enables for channels 0 to 3. All other bits read 0.
  - Port-mask registers (indices 1, 3, 5, 7) keep all 32 bits. Subport-mask registers (indices 2, 4, 6, 8) keep bits 15:0. The timer load register (index 15) keeps 32 bits.
- R3: While the global enable is set, the request counter (index 9) adds one in every cycle in which any bit of `req_major` or `req_sub` is high. While the enable is clear, no counter changes except through a clear.
- R4: While enabled, the grant counter (index 10) adds one for every cycle with `gnt_vld` high, whatever the filter settings.
- R5: Channel n counts into index 11+n. With bit 23 of its port mask clear, it counts a grant when the global enable and channel bit n are set, `gnt_dev` is 0, and bit `gnt_id` of its port mask is set.
- R6: With bit 23 of its port mask set, channel n counts only grants with `gnt_dev`=1 whose index `gnt_id` is below 16 and has its bit set in the subport mask. Major-port grants are then ignored by that channel.
- R7: One grant can add to several channels in the same cycle. A channel whose two filter registers are both zero counts nothing.
- R8: Every counter stops at all ones (2^CNT_W-1) and does not wrap.
- R9: Window mode applies while both the enable and window mode are set and the load value L is not zero. A window ends on every L-th cycle. At that cycle:
  - each snapshot takes its counter's value including that cycle's event, and the live counters restart from 0;
  - while window mode is set, count registers read their snapshots; otherwise they read the live values;
  - writing the timer register restarts the window;
  - a load value of 0 never ends a window.
- R10: The end of a window sets the interrupt flag, and `irq` follows it. A control write with bit 30 set clears the flag; a control write with bit 30 clear leaves it as it is. A window that ends in the same cycle as a clearing write leaves the flag set.
- R11: Any write to a count register (indices 9 to 14) clears that counter and its snapshot, whatever data is written, and takes priority over an increment in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte address of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| req_major | input | NUM_MAJOR | Request strobes from the major ports |
| req_sub | input | NUM_SUB | Request strobes from the device-group subports |
| gnt_vld | input | 1 | A grant is issued this cycle |
| gnt_dev | input | 1 | The grant goes to the device group (1) or to a major port (0) |
| gnt_id | input | ID_W | Major port index, or subport index when `gnt_dev` is 1 |
| irq | output | 1 | Interrupt, mirrors the control flag bit |

## Verification
The assertions assume that `gnt_id` is meaningful only while `gnt_vld` is high. They also assume that software writes the timer register only to restart a window, so that once a window ends the down-counter reloads from a load value that has not changed. The stimulus keeps grant index, device flag and request vectors random in every cycle, including subport indices above 15. Register writes occur only in directed cycles that carry no other bus access. Window mode is run with a short load value, so that many windows end and some of them coincide with flag-clearing writes.

// File: rtl/mbm_pkg.sv
package mbm_pkg;
  localparam int REG_W      = 32;
  localparam int NCH        = 4;
  localparam int NCNT       = 2 + NCH;
  localparam int IDX_CTRL   = 0;
  localparam int IDX_CNT0   = 9;
  localparam int IDX_TMR    = 15;
  localparam int BIT_EN     = 31;
  localparam int BIT_IRQ    = 30;
  localparam int BIT_TMODE  = 20;
  localparam int BIT_DEVSEL = 23;
  localparam int CNT_REQ    = 0;
  localparam int CNT_GNT    = 1;
endpackage

// File: rtl/mbm_chan_filter.sv
module mbm_chan_filter import mbm_pkg::*; #(
  parameter int NUM_SUB = 16,
  parameter int ID_W    = 5
) (
  input  logic [REG_W-1:0]   port_mask,
  input  logic [NUM_SUB-1:0] sub_mask,
  input  logic               gnt_vld,
  input  logic               gnt_dev,
  input  logic [ID_W-1:0]    gnt_id,
  output logic               hit
);
  localparam int SUB_IW = $clog2(NUM_SUB);

  logic in_range;
  logic sub_hit;
  logic maj_hit;

  generate
    if (ID_W > SUB_IW) begin : g_rng
      assign in_range = (gnt_id[ID_W-1:SUB_IW] == '0);
    end else begin : g_full
      assign in_range = 1'b1;
    end
  endgenerate

  assign sub_hit = gnt_dev && in_range && sub_mask[gnt_id[SUB_IW-1:0]];
  assign maj_hit = !gnt_dev && port_mask[gnt_id];
  assign hit     = gnt_vld && (port_mask[BIT_DEVSEL] ? sub_hit : maj_hit);
endmodule

// File: rtl/mbm_sat_counter.sv
module mbm_sat_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             clr,
  input  logic             roll,
  output logic [CNT_W-1:0] live,
  output logic [CNT_W-1:0] snap
);
  logic [CNT_W-1:0] nxt;

  assign nxt = (live == {CNT_W{1'b1}}) ? live : live + CNT_W'(inc);

  always_ff @(posedge clk) begin
    if (rst) begin
      live <= '0;
      snap <= '0;
    end else if (clr) begin
      live <= '0;
      snap <= '0;
    end else if (roll) begin
      snap <= nxt;
      live <= '0;
    end else begin
      live <= nxt;
    end
  end

  // R8
  no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && !roll) |=> (live >= $past(live)));

  // R8
  unit_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && !roll) |=> ((live - $past(live)) <= CNT_W'(1)));

  // R11
  clr_zero_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (live == '0 && snap == '0));
endmodule

// File: rtl/mbm_window_timer.sv
module mbm_window_timer #(
  parameter int TMR_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             wr_load,
  input  logic [TMR_W-1:0] wr_val,
  output logic [TMR_W-1:0] load,
  output logic             expire
);
  logic [TMR_W-1:0] cnt;

  assign expire = run && !wr_load && (load != '0) && (cnt <= TMR_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      load <= '0;
    end else if (wr_load) begin
      load <= wr_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (wr_load) begin
      cnt <= wr_val;
    end else if (!run) begin
      cnt <= load;
    end else if (load != '0) begin
      if (cnt <= TMR_W'(1)) cnt <= load;
      else                  cnt <= cnt - TMR_W'(1);
    end
  end

  // R9
  reload_chk: assert property (@(posedge clk) disable iff (rst)
    expire |=> (cnt == $past(load)));

  // R9
  zero_load_chk: assert property (@(posedge clk) disable iff (rst)
    (load == '0) |-> !expire);
endmodule

// File: rtl/mbm_bw_monitor.sv
module mbm_bw_monitor import mbm_pkg::*; #(
  parameter int NUM_MAJOR = 32,
  parameter int NUM_SUB   = 16,
  parameter int CNT_W     = 32,
  parameter int TMR_W     = 32,
  parameter int ADDR_W    = 6,
  parameter int ID_W      = $clog2(NUM_MAJOR)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reg_wr,
  input  logic                 reg_rd,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [REG_W-1:0]     reg_wdata,
  output logic [REG_W-1:0]     reg_rdata,
  input  logic [NUM_MAJOR-1:0] req_major,
  input  logic [NUM_SUB-1:0]   req_sub,
  input  logic                 gnt_vld,
  input  logic                 gnt_dev,
  input  logic [ID_W-1:0]      gnt_id,
  output logic                 irq
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic             aligned;
  logic             acc_wr;
  logic             acc_rd;
  logic             ctrl_wr;

  logic             ctrl_en;
  logic             ctrl_tmode;
  logic [NCH-1:0]   ctrl_chen;
  logic             irq_flag;

  logic [REG_W-1:0]   pmask [NCH];
  logic [NUM_SUB-1:0] smask [NCH];
  logic [NCH-1:0]     ch_hit;

  logic [NCNT-1:0]  cnt_inc;
  logic [NCNT-1:0]  cnt_clr;
  logic [CNT_W-1:0] cnt_live [NCNT];
  logic [CNT_W-1:0] cnt_snap [NCNT];

  logic [TMR_W-1:0] tmr_load;
  logic             tmr_wr;
  logic             win_end;
  logic [REG_W-1:0] rd_mux;

  assign idx     = reg_addr[ADDR_W-1:2];
  assign aligned = (reg_addr[1:0] == 2'b00);
  assign acc_wr  = reg_wr && aligned;
  assign acc_rd  = reg_rd && aligned;
  assign ctrl_wr = acc_wr && (idx == IDX_W'(IDX_CTRL));
  assign tmr_wr  = acc_wr && (idx == IDX_W'(IDX_TMR));

  // control register and interrupt flag
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_en    <= 1'b0;
      ctrl_tmode <= 1'b0;
      ctrl_chen  <= '0;
    end else if (ctrl_wr) begin
      ctrl_en    <= reg_wdata[BIT_EN];
      ctrl_tmode <= reg_wdata[BIT_TMODE];
      ctrl_chen  <= reg_wdata[NCH-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                                irq_flag <= 1'b0;
    else if (win_end)                       irq_flag <= 1'b1;
    else if (ctrl_wr && reg_wdata[BIT_IRQ]) irq_flag <= 1'b0;
  end

  assign irq = irq_flag;

  // per-channel filter registers and match logic
  generate
    for (genvar n = 0; n < NCH; n++) begin : g_ch
      always_ff @(posedge clk) begin
        if (rst) begin
          pmask[n] <= '0;
        end else if (acc_wr && idx == IDX_W'(2 * n + 1)) begin
          pmask[n] <= reg_wdata;
        end
      end

      always_ff @(posedge clk) begin
        if (rst) begin
          smask[n] <= '0;
        end else if (acc_wr && idx == IDX_W'(2 * n + 2)) begin
          smask[n] <= reg_wdata[NUM_SUB-1:0];
        end
      end

      mbm_chan_filter #(
        .NUM_SUB (NUM_SUB),
        .ID_W    (ID_W)
      ) u_filt (
        .port_mask (pmask[n]),
        .sub_mask  (smask[n]),
        .gnt_vld   (gnt_vld),
        .gnt_dev   (gnt_dev),
        .gnt_id    (gnt_id),
        .hit       (ch_hit[n])
      );

      assign cnt_inc[2 + n] = ctrl_en && ctrl_chen[n] && ch_hit[n];
    end
  endgenerate

  assign cnt_inc[CNT_REQ] = ctrl_en && ((|req_major) || (|req_sub));
  assign cnt_inc[CNT_GNT] = ctrl_en && gnt_vld;

  // counter bank
  generate
    for (genvar k = 0; k < NCNT; k++) begin : g_cnt
      assign cnt_clr[k] = acc_wr && (idx == IDX_W'(IDX_CNT0 + k));

      mbm_sat_counter #(
        .CNT_W (CNT_W)
      ) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .inc  (cnt_inc[k]),
        .clr  (cnt_clr[k]),
        .roll (win_end),
        .live (cnt_live[k]),
        .snap (cnt_snap[k])
      );

      // R3
      en_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_en && !cnt_clr[k]) |=> $stable(cnt_live[k]));
    end
  endgenerate

  mbm_window_timer #(
    .TMR_W (TMR_W)
  ) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .run     (ctrl_en && ctrl_tmode),
    .wr_load (tmr_wr),
    .wr_val  (reg_wdata[TMR_W-1:0]),
    .load    (tmr_load),
    .expire  (win_end)
  );

  // read path
  always_comb begin
    rd_mux = '0;
    if (idx == IDX_W'(IDX_CTRL)) begin
      rd_mux[BIT_EN]    = ctrl_en;
      rd_mux[BIT_IRQ]   = irq_flag;
      rd_mux[BIT_TMODE] = ctrl_tmode;
      rd_mux[NCH-1:0]   = ctrl_chen;
    end
    for (int n = 0; n < NCH; n++) begin
      if (idx == IDX_W'(2 * n + 1)) rd_mux = pmask[n];
      if (idx == IDX_W'(2 * n + 2)) rd_mux = REG_W'(smask[n]);
    end
    for (int k = 0; k < NCNT; k++) begin
      if (idx == IDX_W'(IDX_CNT0 + k))
        rd_mux = REG_W'(ctrl_tmode ? cnt_snap[k] : cnt_live[k]);
    end
    if (idx == IDX_W'(IDX_TMR)) rd_mux = REG_W'(tmr_load);
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (acc_rd) reg_rdata <= rd_mux;
  end

  // R10
  irq_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(win_end));

  // R10
  irq_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (irq && !(ctrl_wr && reg_wdata[BIT_IRQ])) |=> irq);

  // R9
  win_gate_chk: assert property (@(posedge clk) disable iff (rst)
    win_end |-> (ctrl_en && ctrl_tmode));
endmodule

// File: tb/mbm_bw_monitor_bench.sv
`timescale 1ns/1ps
module mbm_bw_monitor_bench;
  localparam int CW   = 10;
  localparam int MAXC = (1 << CW) - 1;

  logic        clk = 1'b0;
  logic        rst;
  logic        reg_wr, reg_rd;
  logic [5:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic [31:0] req_major;
  logic [15:0] req_sub;
  logic        gnt_vld, gnt_dev;
  logic [4:0]  gnt_id;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  bit          m_en, m_tm, m_flag;
  bit [3:0]    m_chen;
  bit [31:0]   m_pm [4];
  bit [15:0]   m_sm [4];
  bit [31:0]   m_load, m_cnt;
  int unsigned m_live [6];
  int unsigned m_snap [6];

  always #10 clk = ~clk;

  mbm_bw_monitor #(.CNT_W(CW)) u_mbm_bw_monitor (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_major(req_major),
    .req_sub(req_sub), .gnt_vld(gnt_vld), .gnt_dev(gnt_dev), .gnt_id(gnt_id), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit f_hit(int n, bit dev, bit [4:0] id);
    if (m_pm[n][23]) return dev && (id < 16) && m_sm[n][id[3:0]];
    return !dev && m_pm[n][id];
  endfunction

  function automatic bit [31:0] f_reg(int ix);
    bit [31:0] v = '0;
    if (ix == 0) begin
      v[31] = m_en; v[30] = m_flag; v[20] = m_tm; v[3:0] = m_chen;
    end else if (ix >= 1 && ix <= 8) begin
      if (ix % 2 == 1) v = m_pm[(ix - 1) / 2];
      else             v = {16'h0, m_sm[(ix - 1) / 2]};
    end else if (ix >= 9 && ix <= 14) begin
      v = m_tm ? m_snap[ix - 9] : m_live[ix - 9];
    end else begin
      v = m_load;
    end
    return v;
  endfunction

  // drive one cycle of inputs and advance the expected state to the next edge
  task automatic apply(input bit wr, input bit rd, input bit [5:0] ad, input bit [31:0] wd,
                       input bit [31:0] rq, input bit [15:0] rs, input bit gv, input bit gd,
                       input bit [4:0] gi);
    bit       w, run, rsta, exp_end;
    bit [5:0] inc;
    int       ix;
    reg_wr = wr; reg_rd = rd; reg_addr = ad; reg_wdata = wd;
    req_major = rq; req_sub = rs; gnt_vld = gv; gnt_dev = gd; gnt_id = gi;
    ix   = int'(ad[5:2]);
    w    = wr && (ad[1:0] == 2'b00);
    run  = m_en && m_tm;
    rsta = w && ix == 15;
    exp_end = run && !rsta && m_load != 0 && m_cnt <= 1;
    inc[0] = m_en && (rq != 0 || rs != 0);
    inc[1] = m_en && gv;
    for (int n = 0; n < 4; n++) inc[2 + n] = m_en && m_chen[n] && gv && f_hit(n, gd, gi);
    for (int k = 0; k < 6; k++) begin
      int unsigned nx = (m_live[k] == MAXC) ? m_live[k] : m_live[k] + inc[k];
      if (w && ix == 9 + k) begin m_live[k] = 0; m_snap[k] = 0; end
      else if (exp_end)     begin m_snap[k] = nx; m_live[k] = 0; end
      else                  m_live[k] = nx;
    end
    if (rsta)              m_cnt = wd;
    else if (!run)         m_cnt = m_load;
    else if (m_load != 0)  m_cnt = (m_cnt <= 1) ? m_load : m_cnt - 1;
    if (exp_end)             m_flag = 1;
    else if (w && ix == 0 && wd[30]) m_flag = 0;
    if (w) begin
      if (ix == 0) begin m_en = wd[31]; m_tm = wd[20]; m_chen = wd[3:0]; end
      else if (ix >= 1 && ix <= 8) begin
        if (ix % 2 == 1) m_pm[(ix - 1) / 2] = wd;
        else             m_sm[(ix - 1) / 2] = wd[15:0];
      end else if (ix == 15) m_load = wd;
    end
  endtask

  task automatic step(input bit wr, input bit rd, input bit [5:0] ad, input bit [31:0] wd,
                      input bit [31:0] rq, input bit [15:0] rs, input bit gv, input bit gd,
                      input bit [4:0] gi);
    @(negedge clk);
    chk(irq === m_flag, "R10 irq", {31'b0, irq}, {31'b0, m_flag});
    apply(wr, rd, ad, wd, rq, rs, gv, gd, gi);
  endtask

  task automatic wr_reg(input int ix, input bit [31:0] v);
    step(1, 0, 6'(ix * 4), v, 0, 0, 0, 0, 0);
  endtask

  task automatic idle(input int n);
    repeat (n) step(0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic rd_chk(input int ix, input string tag);
    bit [31:0] e = f_reg(ix);
    step(0, 1, 6'(ix * 4), 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    chk(irq === m_flag, "R10 irq", {31'b0, irq}, {31'b0, m_flag});
    chk(reg_rdata === e, tag, reg_rdata, e);
    apply(0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic rnd_traffic(input int n);
    repeat (n) begin
      bit gd = 1'($urandom % 2);
      step(0, 0, 0, 0,
           ($urandom % 4 == 0) ? 32'h0 : $urandom,
           ($urandom % 3 == 0) ? 16'($urandom) : 16'h0,
           ($urandom % 3) != 0, gd,
           gd ? 5'($urandom % 20) : 5'($urandom % 32));
    end
  endtask

  task automatic rd_counts(input string tag);
    rd_chk(9, {tag, " R3 req count"});
    rd_chk(10, {tag, " R4 grant count"});
    rd_chk(11, {tag, " R5 ch0 major"});
    rd_chk(12, {tag, " R6 ch1 device"});
    rd_chk(13, {tag, " R7 ch2 overlap"});
    rd_chk(14, {tag, " R7 ch3 empty"});
  endtask

  initial begin
    #(20ns * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int unsigned seed_sink;
    seed_sink = $urandom(32'd4242);
    rst = 1'b1;
    apply(0, 0, 0, 0, 0, 0, 0, 0, 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    for (int i = 0; i < 16; i++) rd_chk(i, "R1 reset value");

    // R2 register access and field widths
    wr_reg(1, 32'hA5A5_5A5A);
    rd_chk(1, "R2 port mask");
    wr_reg(2, 32'hFFFF_1234);
    rd_chk(2, "R2 subport mask width");
    wr_reg(15, 32'h1234_5678);
    rd_chk(15, "R2 timer load");
    step(1, 0, 6'h05, 32'h0000_0001, 0, 0, 0, 0, 0);
    rd_chk(1, "R2 misaligned write ignored");
    wr_reg(0, 32'hBFEF_FFF0);
    rd_chk(0, "R2 control fields");
    wr_reg(0, 32'h0);
    wr_reg(15, 32'h0);

    // filters: ch0 ports 4..7, ch1 device subports, ch2 ports 4..5, ch3 empty
    wr_reg(1, 32'h0000_00F0); wr_reg(2, 32'h0000_FFFF);
    wr_reg(3, 32'h0080_0000); wr_reg(4, 32'h0000_00A5);
    wr_reg(5, 32'h0000_0030); wr_reg(6, 32'h0000_FFFF);
    wr_reg(7, 32'h0);         wr_reg(8, 32'h0);
    for (int i = 9; i <= 14; i++) wr_reg(i, 32'h0);

    // R3 R4 R5 R6 R7 random traffic, then frozen while disabled
    wr_reg(0, 32'h8000_000F);
    rnd_traffic(300);
    wr_reg(0, 32'h0);
    rnd_traffic(20);
    rd_counts("main");

    // R5 channel enables gate individual channels
    wr_reg(0, 32'h8000_0005);
    rnd_traffic(150);
    wr_reg(0, 32'h0);
    rd_counts("chan-enable");

    // R11 write clears, data ignored, wins over increment
    wr_reg(9, 32'h0000_0055);
    rd_chk(9, "R11 clear by write");
    wr_reg(0, 32'h8000_000F);
    step(1, 0, 6'(10 * 4), 32'hFFFF_FFFF, 32'h1, 0, 1, 0, 5'd4);
    wr_reg(0, 32'h0);
    rd_chk(10, "R11 clear beats increment");
    rd_chk(9, "R3 single request");

    // R8 saturation
    for (int i = 9; i <= 14; i++) wr_reg(i, 32'h0);
    wr_reg(0, 32'h8000_000F);
    repeat (MAXC + 80) step(0, 0, 0, 0, 32'h1, 0, 1, 0, 5'd4);
    wr_reg(0, 32'h0);
    rd_chk(9, "R8 request saturates");
    rd_chk(10, "R8 grant saturates");
    rd_chk(11, "R8 channel saturates");

    // R9 R10 timed windows
    for (int i = 9; i <= 14; i++) wr_reg(i, 32'h0);
    wr_reg(15, 32'd7);
    wr_reg(0, 32'h8010_000F);
    rnd_traffic(30);
    rd_counts("window");
    rd_chk(0, "R10 flag readback");
    wr_reg(0, f_reg(0));
    rnd_traffic(9);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk(irq === 1'b1, "R10 flag set again", {31'b0, irq}, 32'h1);
    wr_reg(0, 32'h8010_000F);
    @(negedge clk);
    chk(irq === 1'b1, "R10 write without bit30 keeps flag", {31'b0, irq}, 32'h1);
    apply(0, 0, 0, 0, 0, 0, 0, 0, 0);
    wr_reg(15, 32'd5);
    rnd_traffic(23);
    rd_counts("restart");
    wr_reg(0, 32'h8000_000F);
    rd_chk(9, "R9 live read outside window mode");

    // R9 zero load never ends a window
    wr_reg(0, 32'h4000_0000);
    wr_reg(15, 32'h0);
    wr_reg(0, 32'h8010_000F);
    rnd_traffic(40);
    @(negedge clk);
    chk(irq === 1'b0, "R9 zero load no window end", {31'b0, irq}, 32'h0);
    apply(0, 0, 0, 0, 0, 0, 0, 0, 0);
    idle(2);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule